// File: doc/BRIEF.md
# FIFO Packetizer with Wait States

This block takes words from a FIFO-style port and turns them into a byte stream cut into packets of fixed length. The stream goes to a link transmitter. The block has two roles, chosen by a static mode pin:

- **Active role.** The block is the master of an external FIFO. It watches that FIFO's empty flag and drives its read strobe.
- **Passive role.** An external controller writes words into a 16-entry FIFO inside the block. It uses a write strobe and watches a full flag.

Every FIFO access is stretched by a programmable number of wait states, from 0 to 7. This applies to both roles.

The data port is 16 bits wide and runs in one of two widths:

- **Narrow (8-bit) mode.** Only the low byte of each word is used.
- **Wide (16-bit) mode.** Each word yields two bytes, low byte first.

The packet length is counted in bytes. It comes from one of two sources, picked by a select pin: a configuration value, or a set of external length pins. The block flags the last byte of each packet. The output is a valid/ready byte stream:

- A byte moves when valid and ready are both high on the same rising clock edge.
- While valid is high and ready is low, the byte and its end flag stay frozen.
- Valid never drops until the byte is taken.

Configuration inputs are meant to change only while no access is in progress.

Top module: `fpk_packetizer`

## Requirements
- R1: While reset is asserted and on the first edge after it is released: out_valid_o = 0, ext_rd_o = 0, in_empty_o = 1, in_full_o = 0.
- R2: In active role (mode_passive_i = 0), a read access starts only if ext_empty_i was low in the cycle before ext_rd_o rises. ext_rd_o stays high for exactly ws_i+1 consecutive cycles. ext_data_i is captured on the rising edge that ends the last of those cycles.
- R3: In passive role (mode_passive_i = 1), the internal FIFO behaves as follows:
  - in_wr_i pushes in_data_i into the FIFO on a rising edge.
  - The FIFO holds 16 words. in_full_o is high exactly when it holds 16, and in_empty_o is high exactly when it holds none.
  - A write while in_full_o is high is dropped.
  - ext_rd_o stays low in this role.
- R4: Byte order follows the width mode:
  - Narrow (wide_i = 0): each word yields one byte, taken from bits [7:0].
  - Wide (wide_i = 1): each word yields bits [7:0] first, then bits [15:8].
- R5: out_last_o is high with every Nth byte of the stream, counted from reset. N is chosen by len_sel_ext_i: len_pin_i when it is 1, len_reg_i when it is 0. The length is sampled when the first byte of each packet is offered.
- R6: Each byte counts once toward N, so in wide mode a word counts as two. cfg_err_o is high when the selected length is 0, or when wide_i = 1 and the length is odd. While cfg_err_o is high no new access starts. Once the error clears, transfers resume.
- R7: While out_valid_o is high and out_ready_i is low, on the next cycle out_valid_o stays high and out_data_o and out_last_o are unchanged.
- R8: This rule covers out_ready_i held high with the source never empty. In narrow mode, one byte is offered every ws_i+2 cycles. In wide mode, two bytes are offered every ws_i+3 cycles, on back-to-back cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_passive_i | input | 1 | 1: internal FIFO fed by an external writer; 0: block reads an external FIFO |
| wide_i | input | 1 | 1: 16-bit words, two bytes each; 0: 8-bit, low byte only |
| ws_i | input | 3 | Wait states added to every FIFO access |
| len_sel_ext_i | input | 1 | 1: packet length from len_pin_i; 0: from len_reg_i |
| len_reg_i | input | 8 | Configured packet length in bytes |
| len_pin_i | input | 8 | Packet length from external pins, in bytes |
| ext_empty_i | input | 1 | Empty flag of the external FIFO |
| ext_rd_o | output | 1 | Read strobe to the external FIFO |
| ext_data_i | input | 16 | Read data from the external FIFO |
| in_wr_i | input | 1 | Write strobe into the internal FIFO |
| in_data_i | input | 16 | Write data into the internal FIFO |
| in_full_o | output | 1 | Internal FIFO holds 16 words |
| in_empty_o | output | 1 | Internal FIFO holds no word |
| out_valid_o | output | 1 | Output byte is offered |
| out_ready_i | input | 1 | Link side accepts the byte |
| out_data_o | output | 8 | Output byte |
| out_last_o | output | 1 | Offered byte ends a packet |
| cfg_err_o | output | 1 | Selected packet length is unusable |

## Verification
The following are checked by assertions on every cycle:

- the reset-release state;
- that a read strobe rises only after a non-empty cycle with no configuration error;
- that the strobe stays off in the passive role;
- the freeze rule under back-pressure;
- that the full and empty flags never coincide;
- that the end flag appears only on an offered byte.

The remaining behaviours come out only of the bench's scenarios:

- strobe length against the wait-state setting;
- byte order in each width;
- packet boundaries from the chosen length source;
- words dropped when writing into a full FIFO;
- the exact byte rate per wait setting.

// File: rtl/fpk_pkg.sv
package fpk_pkg;
  // How many bytes of the held word are still to be offered.
  typedef enum logic [1:0] {
    PEND_NONE = 2'd0,
    PEND_LAST = 2'd1,
    PEND_BOTH = 2'd2
  } pend_e;
endpackage

// File: rtl/fpk_sync_fifo.sv
module fpk_sync_fifo #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              full_o,
  output logic              empty_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = AW + 1;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [AW-1:0]     wr_ptr_q, rd_ptr_q;
  logic [CW-1:0]     count_q;
  logic              do_push, do_pop;

  assign full_o  = (count_q == CW'(DEPTH));
  assign empty_o = (count_q == '0);
  assign do_push = push_i & ~full_o;
  assign do_pop  = pop_i & ~empty_o;
  assign rdata_o = mem_q[rd_ptr_q];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= bump(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= bump(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end
endmodule

// File: rtl/fpk_wait_seq.sv
module fpk_wait_seq #(
  parameter int WS_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start_i,
  input  logic [WS_W-1:0] ws_i,
  output logic            busy_o,
  output logic            fire_o
);
  logic [WS_W-1:0] cnt_q;
  logic            busy_q;

  assign busy_o = busy_q;
  assign fire_o = busy_q & (cnt_q == ws_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (!busy_q) begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (fire_o) begin
      busy_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/fpk_framer.sv
module fpk_framer
  import fpk_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wide_i,
  input  logic [LEN_W-1:0]    len_i,
  input  logic                load_i,
  input  logic [2*BYTE_W-1:0] load_word_i,
  output logic                room_o,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [BYTE_W-1:0]   out_data_o,
  output logic                out_last_o
);
  localparam int WORD_W = 2 * BYTE_W;

  pend_e             pend_q;
  logic [WORD_W-1:0] word_q;
  logic              first_q;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  rem;
  logic              hs;

  assign out_valid_o = (pend_q != PEND_NONE);
  assign hs          = out_valid_o & out_ready_i;
  assign rem         = first_q ? len_i : cnt_q;
  assign out_last_o  = out_valid_o & (rem == LEN_W'(1));
  assign out_data_o  = word_q[BYTE_W-1:0];
  assign room_o      = (pend_q == PEND_NONE) | ((pend_q == PEND_LAST) & hs);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= PEND_NONE;
      word_q <= '0;
    end else if (load_i) begin
      if (wide_i) begin
        word_q <= load_word_i;
        pend_q <= PEND_BOTH;
      end else begin
        word_q <= {{BYTE_W{1'b0}}, load_word_i[BYTE_W-1:0]};
        pend_q <= PEND_LAST;
      end
    end else if (hs) begin
      if (pend_q == PEND_BOTH) begin
        word_q <= word_q >> BYTE_W;
        pend_q <= PEND_LAST;
      end else begin
        pend_q <= PEND_NONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= 1'b1;
      cnt_q   <= '0;
    end else if (hs) begin
      if (rem == LEN_W'(1)) begin
        first_q <= 1'b1;
      end else begin
        first_q <= 1'b0;
        cnt_q   <= rem - 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpk_packetizer.sv
module fpk_packetizer #(
  parameter int BYTE_W     = 8,
  parameter int LEN_W      = 8,
  parameter int WS_W       = 3,
  parameter int FIFO_DEPTH = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_passive_i,
  input  logic                wide_i,
  input  logic [WS_W-1:0]     ws_i,
  input  logic                len_sel_ext_i,
  input  logic [LEN_W-1:0]    len_reg_i,
  input  logic [LEN_W-1:0]    len_pin_i,
  input  logic                ext_empty_i,
  output logic                ext_rd_o,
  input  logic [2*BYTE_W-1:0] ext_data_i,
  input  logic                in_wr_i,
  input  logic [2*BYTE_W-1:0] in_data_i,
  output logic                in_full_o,
  output logic                in_empty_o,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic [BYTE_W-1:0]   out_data_o,
  output logic                out_last_o,
  output logic                cfg_err_o
);
  localparam int WORD_W = 2 * BYTE_W;

  logic [LEN_W-1:0]  len_eff;
  logic [WORD_W-1:0] fifo_rdata, src_word;
  logic              src_empty, room, busy, fire, start;

  assign len_eff   = len_sel_ext_i ? len_pin_i : len_reg_i;
  assign cfg_err_o = (len_eff == '0) | (wide_i & len_eff[0]);
  assign src_empty = mode_passive_i ? in_empty_o : ext_empty_i;
  assign src_word  = mode_passive_i ? fifo_rdata : ext_data_i;
  assign start     = ~busy & ~cfg_err_o & ~src_empty & room;
  assign ext_rd_o  = busy & ~mode_passive_i;

  fpk_sync_fifo #(.DATA_W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk     (clk),
    .rst_n   (rst_n),
    .push_i  (in_wr_i),
    .wdata_i (in_data_i),
    .pop_i   (fire & mode_passive_i),
    .rdata_o (fifo_rdata),
    .full_o  (in_full_o),
    .empty_o (in_empty_o)
  );

  fpk_wait_seq #(.WS_W(WS_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (start),
    .ws_i    (ws_i),
    .busy_o  (busy),
    .fire_o  (fire)
  );

  fpk_framer #(.BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_framer (
    .clk         (clk),
    .rst_n       (rst_n),
    .wide_i      (wide_i),
    .len_i       (len_eff),
    .load_i      (fire),
    .load_word_i (src_word),
    .room_o      (room),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .out_data_o  (out_data_o),
    .out_last_o  (out_last_o)
  );
endmodule

// File: rtl/fpk_packetizer_chk.sv
module fpk_packetizer_chk #(
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_passive_i,
  input logic              ext_empty_i,
  input logic              ext_rd_o,
  input logic              cfg_err_o,
  input logic              in_full_o,
  input logic              in_empty_o,
  input logic              out_valid_o,
  input logic              out_ready_i,
  input logic [BYTE_W-1:0] out_data_o,
  input logic              out_last_o
);
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid_o && !ext_rd_o && in_empty_o && !in_full_o));

  p_rd_needs_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_rd_o) |-> $past(!ext_empty_i));

  p_no_strobe_passive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mode_passive_i |-> !ext_rd_o);

  p_flags_exclusive_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_full_o && in_empty_o));

  p_last_with_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_last_o |-> out_valid_o);

  p_no_access_on_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_rd_o) |-> !$past(cfg_err_o));

  p_hold_under_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_data_o) && $stable(out_last_o)));
endmodule

bind fpk_packetizer fpk_packetizer_chk #(.BYTE_W(BYTE_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .mode_passive_i (mode_passive_i),
  .ext_empty_i    (ext_empty_i),
  .ext_rd_o       (ext_rd_o),
  .cfg_err_o      (cfg_err_o),
  .in_full_o      (in_full_o),
  .in_empty_o     (in_empty_o),
  .out_valid_o    (out_valid_o),
  .out_ready_i    (out_ready_i),
  .out_data_o     (out_data_o),
  .out_last_o     (out_last_o)
);

// File: tb/fpk_packetizer_bench.sv
module fpk_packetizer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_passive_i = 1'b0, wide_i = 1'b0, len_sel_ext_i = 1'b0;
  logic [2:0]  ws_i = '0;
  logic [7:0]  len_reg_i = 8'd1, len_pin_i = 8'd1;
  logic        ext_empty_i = 1'b1, ext_rd_o;
  logic [15:0] ext_data_i = '0, in_data_i = '0;
  logic        in_wr_i = 1'b0, in_full_o, in_empty_o;
  logic        out_valid_o, out_ready_i = 1'b1, out_last_o, cfg_err_o;
  logic [7:0]  out_data_o;

  always #2 clk = ~clk;

  fpk_packetizer u_fpk_packetizer (.*);

  int n_checks = 0, n_fail = 0, cyc = 0;
  logic [15:0] words [64];
  int src_ptr = 0, src_n = 0, feed_n = 0, feed_cnt = 0;
  bit feed_on = 0, feed_force = 0, mon_on = 0, pop_pend = 0, rd_seen = 0;
  int hs_idx = 0, total_bytes = 0, pkt_len = 1, rdy_mode = 0;
  int first_hs = 0, last_hs = 0;
  bit pv = 0, pr = 0, pl = 0, prd = 0, pempty = 1;
  logic [7:0] pd = '0;
  int run = 0, rdc = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i);
    if (wide_i) return (i % 2 == 1) ? words[i/2][15:8] : words[i/2][7:0];
    return words[i][7:0];
  endfunction

  // Monitor: samples at the falling edge.
  initial forever begin
    @(negedge clk);
    if (!mon_on) begin
      pv = 0; prd = 0; run = 0; rdc = 0;
    end else begin
      if (out_valid_o && out_ready_i) begin
        if (hs_idx >= total_bytes)
          check(0, "R5", "byte beyond stream end", hs_idx, total_bytes);
        else begin
          check(out_data_o == exp_byte(hs_idx), "R4", "byte value",
                out_data_o, exp_byte(hs_idx));
          check(out_last_o == ((hs_idx % pkt_len) == pkt_len - 1), "R5",
                "end flag", out_last_o, int'((hs_idx % pkt_len) == pkt_len - 1));
        end
        if (hs_idx == 0) first_hs = cyc;
        last_hs = cyc;
        hs_idx++;
      end
      if (pv && !pr)
        check(out_valid_o && out_data_o == pd && out_last_o == pl, "R7",
              "stalled byte held", out_data_o, pd);
      if (mode_passive_i && ext_rd_o)
        check(0, "R3", "strobe in passive role", 1, 0);
      if (ext_rd_o && !prd) begin
        rd_seen = 1;
        check(!pempty, "R2", "read started on empty", int'(pempty), 0);
      end
      if (!ext_rd_o && prd)
        check(run == int'(ws_i) + 1, "R2", "strobe length", run, int'(ws_i) + 1);
      if (ext_rd_o) begin
        run++;
        if (rdc == int'(ws_i)) begin pop_pend = 1; rdc = 0; end
        else rdc++;
      end else run = 0;
      pv = out_valid_o; pr = out_ready_i; pd = out_data_o; pl = out_last_o;
      prd = ext_rd_o; pempty = ext_empty_i;
    end
  end

  // Drivers: external FIFO model, ready pattern, passive writer.
  initial forever begin
    @(posedge clk); #1;
    if (pop_pend) begin src_ptr++; pop_pend = 0; end
    ext_empty_i = (src_ptr >= src_n);
    ext_data_i  = words[src_ptr % 64];
    case (rdy_mode)
      0: out_ready_i = 1'b1;
      1: out_ready_i = 1'b0;
      default: out_ready_i = ((cyc % 3) != 1);
    endcase
    if (feed_on && feed_cnt < feed_n && (feed_force || !in_full_o)) begin
      in_wr_i = 1'b1; in_data_i = words[feed_cnt]; feed_cnt++;
    end else in_wr_i = 1'b0;
  end

  task automatic setup(input bit pas, input bit wd, input int w, input bit lsel,
                       input int len, input int nw, input int rdy,
                       input bit frc, input int nfeed);
    mon_on = 0; rst_n = 0; feed_on = 0;
    mode_passive_i = pas; wide_i = wd; ws_i = 3'(w); len_sel_ext_i = lsel;
    if (lsel) begin len_pin_i = 8'(len); len_reg_i = 8'(len + 1); end
    else      begin len_reg_i = 8'(len); len_pin_i = 8'(len + 1); end
    for (int k = 0; k < 64; k++)
      words[k] = {8'(k * 29 + len * 3 + w + 90), 8'(k * 11 + w * 7 + 1)};
    src_ptr = 0; src_n = pas ? 0 : nw; feed_n = nfeed; feed_cnt = 0;
    feed_force = frc; hs_idx = 0; total_bytes = wd ? 2 * nw : nw;
    pkt_len = (len > 0) ? len : 1; rdy_mode = rdy; pop_pend = 0; rd_seen = 0;
    ext_empty_i = (src_n == 0);
    repeat (2) @(posedge clk);
    #2;
    check(!out_valid_o && !ext_rd_o && in_empty_o && !in_full_o, "R1",
          "reset state", int'({out_valid_o, ext_rd_o, in_empty_o, in_full_o}), 2);
    rst_n = 1; mon_on = 1; feed_on = pas;
  endtask

  task automatic wait_done(input int limit);
    for (int t = 0; t < limit && hs_idx < total_bytes; t++) @(posedge clk);
    check(hs_idx == total_bytes, "R5", "bytes delivered", hs_idx, total_bytes);
  endtask

  // Burst rate with a preloaded internal FIFO and dropped overflow writes.
  task automatic rate_test(input bit wd, input int w);
    setup(1, wd, w, 0, 2, 17, 1, 1, 20);
    repeat (40) @(posedge clk);
    #2;
    check(in_full_o && !in_empty_o, "R3", "full after 16 held",
          int'({in_full_o, in_empty_o}), 2);
    rdy_mode = 0;
    wait_done(2000);
    if (wd) check(last_hs - first_hs == 16 * (w + 3) + 1, "R8", "wide burst span",
                  last_hs - first_hs, 16 * (w + 3) + 1);
    else    check(last_hs - first_hs == 16 * (w + 2), "R8", "narrow burst span",
                  last_hs - first_hs, 16 * (w + 2));
    repeat (20) @(posedge clk);
    #2;
    check(!out_valid_o && hs_idx == 34 / (wd ? 1 : 2), "R3", "overflow writes dropped",
          hs_idx, 34 / (wd ? 1 : 2));
    check(in_empty_o && !in_full_o, "R3", "empty after drain",
          int'({in_full_o, in_empty_o}), 1);
  endtask

  initial begin
    // Main sweep: role x width x wait states x length, both length sources.
    for (int pas = 0; pas < 2; pas++)
      for (int wd = 0; wd < 2; wd++)
        for (int w = 0; w < 8; w++)
          for (int li = 0; li < 3; li++) begin
            setup(pas[0], wd[0], w, ((w + li) % 2) == 1,
                  wd ? 2 + 2 * li : 1 + 2 * li, 12, (li == 1) ? 2 : 0, 0, 12);
            wait_done(3000);
          end

    // R6: unusable lengths block access; clearing the error resumes transfers.
    setup(0, 1, 1, 0, 3, 4, 0, 0, 0);
    repeat (30) @(posedge clk);
    #2;
    check(cfg_err_o, "R6", "odd length in wide mode", int'(cfg_err_o), 1);
    check(!rd_seen && hs_idx == 0, "R6", "no access while in error", hs_idx, 0);
    len_sel_ext_i = 1; len_pin_i = 8'd0; wide_i = 0;
    #1;
    check(cfg_err_o, "R6", "zero length", int'(cfg_err_o), 1);
    len_pin_i = 8'd1;
    #1;
    check(!cfg_err_o, "R6", "narrow length one accepted", int'(cfg_err_o), 0);
    len_pin_i = 8'd4; wide_i = 1; pkt_len = 4;
    #1;
    check(!cfg_err_o, "R6", "even length in wide mode", int'(cfg_err_o), 0);
    wait_done(500);

    for (int w = 0; w < 8; w += 3) begin
      rate_test(0, w);
      rate_test(1, w);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 190000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule